// File: doc/BRIEF.md
# Slot Address Base Selector

This block decides, once per reset, which 5-bit slot number the card uses as the base for its short-address register window and its configuration-space window. It reads the backplane slot lines and the backplane parity line and accepts them only when both checks pass. The parity check is odd parity over the six lines. The range check requires a slot number from 1 to 21 inclusive. When a check fails, or when the local override switch is closed, the value on a 5-bit local switch bank is used instead.

All inputs are brought through a two-stage synchronizer. The choice is taken on the 8th rising clock edge after reset is released and is then frozen until the next reset. The block reports the chosen value, a valid flag, whether the local bank was used, and whether the backplane lines failed their check.

After the choice is made, the short-address base can be rewritten through a single load port. The configuration-space base always keeps the selected slot value. The block has no streaming data path, so every pin is a plain level or pulse and there is no back-pressure.

Top module: `gab_base_select`

## Requirements
- R1: While reset is asserted, and until the choice is taken, `cfg_base_o` and `short_base_o` are 0, and `base_valid_o`, `use_local_o` and `bp_fault_o` are 0.
- R2: `base_valid_o` is 0 after the 7th rising edge following reset release and is 1 after the 8th.
- R3: The backplane value is accepted when the XOR of the 5 slot bits and the parity bit is 1 and the value is between 1 and 21 inclusive. Both boundaries are accepted. When it is accepted and the override is open, both bases equal the backplane value, `use_local_o`=0 and `bp_fault_o`=0.
- R4: If the backplane parity is wrong, both bases take the local switch value, with `use_local_o`=1 and `bp_fault_o`=1.
- R5: A backplane value of 0 or 22 to 31 with correct parity is rejected, with the same outcome as R4.
- R6: When the override switch is 1, the local switch value is used whatever the backplane lines carry, and `use_local_o`=1. `bp_fault_o` still reports the outcome of the backplane check.
- R7: The local value is used unchanged even when it is itself outside 1 to 21 (for example 0 or 31).
- R8: Once `base_valid_o` is 1, changes on the backplane, switch or override inputs have no effect on any output until the next reset.
- R9: When `base_valid_o` is 1, a pulse on `short_ld_i` sets `short_base_o` to `short_ld_val_i` after the next rising edge. `cfg_base_o` does not change.
- R10: A load pulse that arrives before `base_valid_o` rises is ignored. `short_base_o` then takes the selected value when the choice is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bp_slot_i | input | 5 | Backplane slot number lines (asynchronous) |
| bp_par_i | input | 1 | Backplane parity line (asynchronous) |
| sw_slot_i | input | 5 | Local switch bank slot value (asynchronous) |
| sw_force_i | input | 1 | Local override switch, 1 = use the switch bank |
| short_ld_i | input | 1 | One-cycle pulse that rewrites the short-address base |
| short_ld_val_i | input | 5 | Value written by `short_ld_i` |
| cfg_base_o | output | 5 | Configuration-space base slot |
| short_base_o | output | 5 | Short-address register base slot |
| base_valid_o | output | 1 | The choice has been taken |
| use_local_o | output | 1 | 1 when the local switch value was chosen |
| bp_fault_o | output | 1 | 1 when the backplane lines failed parity or range |

## Verification
The bench targets the exact edge on which the choice lands. A design that samples one edge early or late fails the 7th/8th-edge probe. It also probes the range boundaries: slots 1 and 21 must be accepted, while 0 and 22 carrying correct parity must fall back to the switches. A design with an off-by-one compare, or one that checks only parity, selects the wrong source there. Further checks cover the override with a good backplane value, which must still report no fault, and local values of 0 and 31, which a design that "repairs" invalid switch values would alter. The bench also changes the inputs after the choice and loads the short base both before and after it. This catches a design that keeps tracking its inputs, lets a load touch the configuration base, or honours an early load.

// File: rtl/gab_pkg.sv
package gab_pkg;

  localparam int unsigned SLOT_W = 5;

  typedef logic [SLOT_W-1:0] slot_t;

  // Odd parity over the slot bits plus the parity bit: XOR of all six is 1.
  function automatic logic odd_parity_ok(input slot_t slot, input logic par);
    return (^{slot, par}) == 1'b1;
  endfunction

  function automatic logic slot_in_range(input slot_t slot,
                                         input int unsigned lo,
                                         input int unsigned hi);
    return (int'(slot) >= int'(lo)) && (int'(slot) <= int'(hi));
  endfunction

endpackage

// File: rtl/gab_sync.sv
module gab_sync #(
  parameter int unsigned W      = 12,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/gab_settle_timer.sv
module gab_settle_timer #(
  parameter int unsigned SETTLE_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic capture_o,
  output logic done_o
);

  localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] STOP = CNT_W'(SETTLE_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (cnt_q != STOP) cnt_q <= cnt_q + 1'b1;
  end

  assign capture_o = (cnt_q == LAST);
  assign done_o    = (cnt_q == STOP);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= STOP); // R2

  AST_SINGLE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    capture_o |=> (!capture_o && done_o)); // R2

endmodule

// File: rtl/gab_check.sv
module gab_check
  import gab_pkg::*;
#(
  parameter int unsigned SLOT_MIN = 1,
  parameter int unsigned SLOT_MAX = 21
) (
  input  slot_t bp_slot_i,
  input  logic  bp_par_i,
  output logic  par_ok_o,
  output logic  range_ok_o,
  output logic  accept_o
);

  always_comb begin
    par_ok_o   = odd_parity_ok(bp_slot_i, bp_par_i);
    range_ok_o = slot_in_range(bp_slot_i, SLOT_MIN, SLOT_MAX);
    accept_o   = par_ok_o && range_ok_o;
  end

endmodule

// File: rtl/gab_base_select.sv
module gab_base_select
  import gab_pkg::*;
#(
  parameter int unsigned SLOT_MIN    = 1,
  parameter int unsigned SLOT_MAX    = 21,
  parameter int unsigned SETTLE_CYC  = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] bp_slot_i,
  input  logic       bp_par_i,
  input  logic [4:0] sw_slot_i,
  input  logic       sw_force_i,
  input  logic       short_ld_i,
  input  logic [4:0] short_ld_val_i,
  output logic [4:0] cfg_base_o,
  output logic [4:0] short_base_o,
  output logic       base_valid_o,
  output logic       use_local_o,
  output logic       bp_fault_o
);

  localparam int unsigned BUS_W = 2 * SLOT_W + 2;

  logic [BUS_W-1:0] raw_bus, syn_bus;
  slot_t bp_slot_s, sw_slot_s;
  logic  bp_par_s, sw_force_s;
  logic  par_ok, range_ok, accept;
  logic  capture, settled;

  assign raw_bus = {bp_slot_i, bp_par_i, sw_slot_i, sw_force_i};

  gab_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_bus),
    .q_o   (syn_bus)
  );

  assign {bp_slot_s, bp_par_s, sw_slot_s, sw_force_s} = syn_bus;

  gab_check #(.SLOT_MIN(SLOT_MIN), .SLOT_MAX(SLOT_MAX)) u_check (
    .bp_slot_i  (bp_slot_s),
    .bp_par_i   (bp_par_s),
    .par_ok_o   (par_ok),
    .range_ok_o (range_ok),
    .accept_o   (accept)
  );

  gab_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_o (capture),
    .done_o    (settled)
  );

  logic  pick_local;
  slot_t pick_slot;

  always_comb begin
    pick_local = sw_force_s || !accept;
    pick_slot  = pick_local ? sw_slot_s : bp_slot_s;
  end

  slot_t cfg_q, short_q;
  logic  valid_q, local_q, fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      short_q <= '0;
      valid_q <= 1'b0;
      local_q <= 1'b0;
      fault_q <= 1'b0;
    end else if (capture && !valid_q) begin
      cfg_q   <= pick_slot;
      short_q <= pick_slot;
      valid_q <= 1'b1;
      local_q <= pick_local;
      fault_q <= !accept;
    end else if (valid_q && short_ld_i) begin
      short_q <= short_ld_val_i;
    end
  end

  assign cfg_base_o   = cfg_q;
  assign short_base_o = short_q;
  assign base_valid_o = valid_q;
  assign use_local_o  = local_q;
  assign bp_fault_o   = fault_q;

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !base_valid_o |-> (cfg_base_o == '0 && short_base_o == '0
                       && !use_local_o && !bp_fault_o)); // R1

  AST_VALID_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    base_valid_o == settled); // R2

  AST_FAULT_GOES_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    bp_fault_o |-> use_local_o); // R4

  AST_FORCE_GOES_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && sw_force_s) |=> use_local_o); // R6

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    base_valid_o |=> (base_valid_o && $stable(cfg_base_o)
                      && $stable(use_local_o) && $stable(bp_fault_o))); // R8

  AST_LOAD_WRITES_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (base_valid_o && short_ld_i) |=> (short_base_o == $past(short_ld_val_i))); // R9

  AST_EARLY_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!base_valid_o && !capture) |=> (short_base_o == '0)); // R10

endmodule

// File: tb/gab_base_select_tb.sv
module gab_base_select_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] bp_slot = '0;
  logic       bp_par = 1'b0;
  logic [4:0] sw_slot = '0;
  logic       sw_force = 1'b0;
  logic       short_ld = 1'b0;
  logic [4:0] short_ld_val = '0;
  logic [4:0] cfg_base, short_base;
  logic       base_valid, use_local, bp_fault;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gab_base_select u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .bp_slot_i      (bp_slot),
    .bp_par_i       (bp_par),
    .sw_slot_i      (sw_slot),
    .sw_force_i     (sw_force),
    .short_ld_i     (short_ld),
    .short_ld_val_i (short_ld_val),
    .cfg_base_o     (cfg_base),
    .short_base_o   (short_base),
    .base_valid_o   (base_valid),
    .use_local_o    (use_local),
    .bp_fault_o     (bp_fault)
  );

  function automatic logic good_par(input logic [4:0] s);
    return ~^s;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_outs(input string req, input int c, input int s,
                            input int v, input int l, input int f);
    chk(req, "cfg_base", cfg_base, c);
    chk(req, "short_base", short_base, s);
    chk(req, "base_valid", base_valid, v);
    chk(req, "use_local", use_local, l);
    chk(req, "bp_fault", bp_fault, f);
  endtask

  // Reset with the given inputs, then run to the decision edge.
  task automatic start(input logic [4:0] bs, input logic bpp,
                       input logic [4:0] ss, input logic frc);
    @(negedge clk);
    rst_n = 1'b0;
    bp_slot = bs; bp_par = bpp; sw_slot = ss; sw_force = frc;
    short_ld = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (7) @(posedge clk);
    @(negedge clk);
    chk("R2", "valid after 7 edges", base_valid, 0);
    @(negedge clk);
    chk("R2", "valid after 8 edges", base_valid, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bp_slot = 5'd5; bp_par = good_par(5'd5);
    repeat (3) @(negedge clk);
    check_outs("R1", 0, 0, 0, 0, 0);
  endtask

  task automatic t_good_slot();
    start(5'd5, good_par(5'd5), 5'd9, 1'b0);
    check_outs("R3", 5, 5, 1, 0, 0);
  endtask

  task automatic t_bounds();
    start(5'd1, good_par(5'd1), 5'd9, 1'b0);
    check_outs("R3", 1, 1, 1, 0, 0);
    start(5'd21, good_par(5'd21), 5'd9, 1'b0);
    check_outs("R3", 21, 21, 1, 0, 0);
    start(5'd22, good_par(5'd22), 5'd9, 1'b0);
    check_outs("R5", 9, 9, 1, 1, 1);
    start(5'd0, good_par(5'd0), 5'd4, 1'b0);
    check_outs("R5", 4, 4, 1, 1, 1);
  endtask

  task automatic t_parity_bad();
    start(5'd7, ~good_par(5'd7), 5'd12, 1'b0);
    check_outs("R4", 12, 12, 1, 1, 1);
  endtask

  task automatic t_force();
    start(5'd5, good_par(5'd5), 5'd3, 1'b1);
    check_outs("R6", 3, 3, 1, 1, 0);
  endtask

  task automatic t_local_invalid();
    start(5'd7, ~good_par(5'd7), 5'd0, 1'b0);
    check_outs("R7", 0, 0, 1, 1, 1);
    start(5'd30, good_par(5'd30), 5'd31, 1'b0);
    check_outs("R7", 31, 31, 1, 1, 1);
  endtask

  task automatic t_hold();
    start(5'd10, good_par(5'd10), 5'd2, 1'b0);
    bp_slot = 5'd3; bp_par = ~good_par(5'd3); sw_slot = 5'd17; sw_force = 1'b1;
    repeat (10) @(negedge clk);
    check_outs("R8", 10, 10, 1, 0, 0);
  endtask

  task automatic t_load();
    start(5'd6, good_par(5'd6), 5'd2, 1'b0);
    short_ld = 1'b1; short_ld_val = 5'd17;
    @(negedge clk);
    short_ld = 1'b0;
    chk("R9", "short after load", short_base, 17);
    chk("R9", "cfg after load", cfg_base, 6);
    @(negedge clk);
    chk("R9", "short holds", short_base, 17);
  endtask

  task automatic t_early_load();
    @(negedge clk);
    rst_n = 1'b0;
    bp_slot = 5'd8; bp_par = good_par(5'd8); sw_slot = 5'd2; sw_force = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    short_ld = 1'b1; short_ld_val = 5'd30;
    @(negedge clk);
    short_ld = 1'b0;
    chk("R10", "short before choice", short_base, 0);
    repeat (6) @(negedge clk);
    check_outs("R10", 8, 8, 1, 0, 0);
  endtask

  initial begin
    t_reset();
    t_good_slot();
    t_bounds();
    t_parity_bad();
    t_force();
    t_local_invalid();
    t_hold();
    t_load();
    t_early_load();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule